// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers a set of active-low external interrupt request pins and turns them into a single prioritized service request for a processor core. Every pin passes through a two-flop synchronizer. Each line can be set up in one of two ways. A level-sensitive line requests while its pin is low. An edge-sensitive line captures a falling transition of the synchronized pin in a sticky latch. A mask register enables lines one by one. A force/clear write port lets software set or drop any latched request.

The core takes an interrupt by pulsing an acknowledge together with the index it took. That acknowledge clears the edge latch of the line. Two inputs hold off recognition. While a multi-cycle external access is in progress, nothing is presented. While the bus is granted away, requests are not presented unless go mode is enabled. Edge latches keep capturing during both kinds of hold-off, so no event is lost.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the mask register, the sense register (all lines level, encoding 0 = level, 1 = edge) and all edge latches are zero, so `req_o` stays low even while pins are held low.
- R2: A pin goes through two synchronizing flops. A level request shows on `req_o` after the second rising clock edge that follows the pin change, and it disappears after the second edge that follows the release.
- R3: On an edge line, a high-to-low transition of the synchronized pin sets the line's latch, which is visible one edge after the synchronized fall. The request then persists whatever level the pin holds, and no new request arises without a new falling transition.
- R4: An acknowledge (`ack_i` with `ack_idx_i`) clears the edge latch of that index at the same clock edge.
- R5: A level line requests for as long as its synchronized pin is low, and an acknowledge does not remove that request.
- R6: A line whose mask bit (bit i = line i) is 0 is never presented. Its edge latch still captures, and the request appears once the line is unmasked.
- R7: Fixed priority: among eligible lines the lowest index wins. `req_idx_o` is its index and `req_onehot_o` has only that bit set.
- R8: While `bus_grant_i` is high and `go_mode_i` is low, `req_o` is low but edge latches still capture. With `go_mode_i` high, requests are presented during bus grant.
- R9: While `ext_busy_i` is high, `req_o` is low. A pending request is presented in the cycle after `ext_busy_i` drops.
- R10: A force/clear write sets the latches selected in `ifc_force_i` and clears those selected in `ifc_clear_i`. Where one bit is both forced and cleared, the force wins.
- R11: If a latch is set and cleared in the same cycle (a new falling edge meeting an acknowledge of the same line), setting wins and the request remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | N_IRQ | Asynchronous request pins, active low |
| sense_we_i | input | 1 | Write strobe for the sense register |
| sense_edge_i | input | N_IRQ | Sense write data, 1 = edge, 0 = level |
| mask_we_i | input | 1 | Write strobe for the mask register |
| mask_i | input | N_IRQ | Mask write data, 1 = enabled |
| ifc_we_i | input | 1 | Force/clear write strobe |
| ifc_force_i | input | N_IRQ | Latches to set |
| ifc_clear_i | input | N_IRQ | Latches to clear |
| bus_grant_i | input | 1 | Bus granted to another master |
| go_mode_i | input | 1 | Allow service during bus grant |
| ext_busy_i | input | 1 | Multi-cycle external access in progress |
| ack_i | input | 1 | Core takes an interrupt this cycle |
| ack_idx_i | input | $clog2(N_IRQ) | Index of the interrupt taken |
| req_o | output | 1 | Service request |
| req_idx_o | output | $clog2(N_IRQ) | Index of the winning line |
| req_onehot_o | output | N_IRQ | One-hot form of the winner |

## Verification
Two events can fall in the same cycle on one line's latch: a clear and a set. One case is an acknowledge arriving together with a fresh synchronized falling edge. The bench first latches an edge request and releases the pin. It then drops the pin again and places the acknowledge exactly in the cycle where the synchronized fall becomes visible, counting the two synchronizer edges. The request must still be present afterwards, with the same index. The other case is a force/clear write that names the same bit in both fields, and it is judged the same way: the latch must stay set.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    GATE_OPEN = 2'd0,
    GATE_BUS  = 2'd1,
    GATE_BUSY = 2'd2
  } gate_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_ni,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
        s3_q <= 1'b1;
      end else begin
        s1_q <= pin_ni[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl_o[i]  = ~s2_q;
    // fall seen on the synchronized copy only
    assign fall_o[i] = s3_q & ~s2_q;
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[i]) q <= 1'b1;
      else if (clr_i[i]) q <= 1'b0;
    end
    assign q_o[i] = q;

    a_r3_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q && !clr_i[i]) |=> q);
    a_r4_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !q);
    a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> q);
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  onehot_o
);
  always_comb begin
    idx_o    = '0;
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o    = IW'(i);
        onehot_o = N'(1) << i;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int N_IRQ = 4,
  localparam int IW   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_ni,
  input  logic             sense_we_i,
  input  logic [N_IRQ-1:0] sense_edge_i,
  input  logic             mask_we_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic             ifc_we_i,
  input  logic [N_IRQ-1:0] ifc_force_i,
  input  logic [N_IRQ-1:0] ifc_clear_i,
  input  logic             bus_grant_i,
  input  logic             go_mode_i,
  input  logic             ext_busy_i,
  input  logic             ack_i,
  input  logic [IW-1:0]    ack_idx_i,
  output logic             req_o,
  output logic [IW-1:0]    req_idx_o,
  output logic [N_IRQ-1:0] req_onehot_o
);
  logic [N_IRQ-1:0] mask_q, edge_q;
  logic [N_IRQ-1:0] lvl, fall, latch_q;
  logic [N_IRQ-1:0] set_v, clr_v, ack_v, raw_v, elig_v, sel_v;
  gate_e            gate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      edge_q <= '0;
    end else begin
      if (mask_we_i)  mask_q <= mask_i;
      if (sense_we_i) edge_q <= sense_edge_i;
    end
  end

  irq_sync #(.N(N_IRQ)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_ni (irq_ni),
    .lvl_o  (lvl),
    .fall_o (fall)
  );

  assign ack_v = ack_i ? (N_IRQ'(1) << ack_idx_i) : '0;
  assign set_v = (fall & edge_q) | (ifc_we_i ? ifc_force_i : '0);
  assign clr_v = ack_v | (ifc_we_i ? ifc_clear_i : '0);

  irq_latch #(.N(N_IRQ)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .q_o    (latch_q)
  );

  assign raw_v  = (lvl & ~edge_q) | latch_q;
  assign elig_v = raw_v & mask_q;

  always_comb begin
    if (ext_busy_i)                      gate = GATE_BUSY;
    else if (bus_grant_i && !go_mode_i)  gate = GATE_BUS;
    else                                 gate = GATE_OPEN;
  end
  assign sel_v = (gate == GATE_OPEN) ? elig_v : '0;

  irq_prio #(.N(N_IRQ), .IW(IW)) u_prio (
    .req_i    (sel_v),
    .any_o    (req_o),
    .idx_o    (req_idx_o),
    .onehot_o (req_onehot_o)
  );

  a_r6_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> mask_q[req_idx_o]);
  a_r7_onehot_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ($onehot0(req_onehot_o) && req_onehot_o[req_idx_o]));
  a_r7_lower_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ((elig_v & ((N_IRQ'(1) << req_idx_o) - N_IRQ'(1))) == '0));
  a_r8_grant_holdoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_grant_i && !go_mode_i) |-> !req_o);
  a_r9_busy_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_busy_i |-> !req_o);
endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_n = '1, sense = '0, mask = '0, frc = '0, clr = '0;
  logic sense_we = 0, mask_we = 0, ifc_we = 0;
  logic bg = 0, go = 0, busy = 0, ack = 0;
  logic [IW-1:0] ack_idx = '0;
  logic req;
  logic [IW-1:0] req_idx;
  logic [N-1:0] req_oh;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_ctrl #(.N_IRQ(N)) u_ext_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n),
    .sense_we_i(sense_we), .sense_edge_i(sense),
    .mask_we_i(mask_we), .mask_i(mask),
    .ifc_we_i(ifc_we), .ifc_force_i(frc), .ifc_clear_i(clr),
    .bus_grant_i(bg), .go_mode_i(go), .ext_busy_i(busy),
    .ack_i(ack), .ack_idx_i(ack_idx),
    .req_o(req), .req_idx_o(req_idx), .req_onehot_o(req_oh)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_req(string tag, bit r, int idx);
    check(tag, req, r);
    if (r) begin
      check(tag, req_idx, idx);
      check(tag, req_oh, 1 << idx);
    end
  endtask

  task automatic wr_sense(logic [N-1:0] v);
    sense = v; sense_we = 1; step(1); sense_we = 0;
  endtask
  task automatic wr_mask(logic [N-1:0] v);
    mask = v; mask_we = 1; step(1); mask_we = 0;
  endtask
  task automatic do_ack(int idx);
    ack = 1; ack_idx = IW'(idx); step(1); ack = 0;
  endtask
  task automatic wr_ifc(logic [N-1:0] f, logic [N-1:0] c);
    frc = f; clr = c; ifc_we = 1; step(1); ifc_we = 0; frc = '0; clr = '0;
  endtask

  task automatic t_reset;
    irq_n = '0;
    step(3);
    rst_n = 1;
    step(3);
    chk_req("R1 reset silent", 0, 0);
    irq_n = '1;
    step(3);
  endtask

  task automatic t_level;
    wr_sense('0); wr_mask('1);
    irq_n[0] = 0;
    step(1); chk_req("R2 one edge not yet", 0, 0);
    step(1); chk_req("R2 two edges", 1, 0);
    do_ack(0); chk_req("R5 level survives ack", 1, 0);
    irq_n[0] = 1;
    step(1); chk_req("R2 release one edge", 1, 0);
    step(1); chk_req("R2 release two edges", 0, 0);
  endtask

  task automatic t_edge;
    wr_sense(4'b0010);
    irq_n[1] = 0;
    step(2); chk_req("R3 not before latch", 0, 0);
    step(1); chk_req("R3 latched", 1, 1);
    step(5); chk_req("R3 persists low", 1, 1);
    do_ack(1); chk_req("R4 ack clears", 0, 0);
    step(3); chk_req("R3 no rerequest while low", 0, 0);
    irq_n[1] = 1;
    step(3); chk_req("R3 rise no request", 0, 0);
    irq_n[1] = 0;
    step(3); chk_req("R3 second fall", 1, 1);
    irq_n[1] = 1;
    do_ack(1); step(3);
    chk_req("R4 cleared after pin high", 0, 0);
  endtask

  task automatic t_prio;
    wr_sense(4'b0100);
    irq_n[3] = 0; irq_n[2] = 0;
    step(3); chk_req("R7 lower index wins", 1, 2);
    do_ack(2); chk_req("R7 next winner", 1, 3);
    irq_n = '1;
    step(3); chk_req("R7 idle", 0, 0);
  endtask

  task automatic t_mask;
    wr_sense(4'b0010); wr_mask(4'b1101);
    irq_n[1] = 0;
    step(4); chk_req("R6 masked", 0, 0);
    irq_n[1] = 1;
    wr_mask('1); chk_req("R6 appears on unmask", 1, 1);
    do_ack(1); chk_req("R6 cleared", 0, 0);
  endtask

  task automatic t_grant;
    bg = 1; go = 0;
    irq_n[1] = 0;
    step(4); chk_req("R8 held off in grant", 0, 0);
    go = 1;
    step(1); chk_req("R8 go mode serves", 1, 1);
    go = 0;
    step(1); chk_req("R8 held again", 0, 0);
    bg = 0; irq_n[1] = 1;
    step(1); chk_req("R8 latched survives grant", 1, 1);
    do_ack(1); chk_req("R8 cleared", 0, 0);
  endtask

  task automatic t_busy;
    wr_sense('0);
    busy = 1; irq_n[3] = 0;
    step(4); chk_req("R9 blocked while busy", 0, 0);
    busy = 0;
    step(1); chk_req("R9 after access", 1, 3);
    irq_n[3] = 1;
    step(2); chk_req("R9 released", 0, 0);
  endtask

  task automatic t_ifc;
    wr_ifc(4'b0001, '0); chk_req("R10 force", 1, 0);
    wr_ifc('0, 4'b0001); chk_req("R10 clear", 0, 0);
    wr_ifc(4'b0100, 4'b0100); chk_req("R10 force beats clear", 1, 2);
    wr_ifc('0, 4'b0100); chk_req("R10 clear again", 0, 0);
  endtask

  task automatic t_same_cycle;
    wr_sense(4'b0010);
    irq_n[1] = 0; step(3);
    irq_n[1] = 1; step(3);
    chk_req("R11 latched before race", 1, 1);
    irq_n[1] = 0; step(2);
    do_ack(1);
    chk_req("R11 set wins over ack", 1, 1);
    do_ack(1);
    chk_req("R11 later ack clears", 0, 0);
    irq_n[1] = 1; step(3);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_prio();
    t_mask();
    t_grant();
    t_busy();
    t_ifc();
    t_same_cycle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule